// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block takes over the memory bus of an 8-bit processor core with a 16-bit address space whenever the core must enter a service routine. It handles four sources: a reset, an edge-triggered non-maskable request, a level-sensitive maskable request, and a software break reported by the core. For every source except reset it saves the return state on a descending stack in page 1. The high byte of the return address is pushed first, then the low byte, then a status byte. It then reads a little-endian two-byte vector and hands the core a new program counter, stack pointer and status byte.

The core tells the sequencer when it stands at an instruction boundary (`at_boundary`) or has just fetched a break opcode (`brk_hit`). With either strobe it supplies the current return address, status byte and stack pointer. From the acceptance cycle onwards the sequencer owns the bus for six cycles and raises `busy`. `done` pulses in the following cycle together with the results. Reset runs the same six bus cycles, but the three stack cycles are reads. Reset leaves the stack pointer three below `$FF`.

The controller has seven states. IDLE waits for an accepted request; after reset the machine starts in DUMMY. DUMMY is a throw-away read at the return address. PUSH_HI, PUSH_LO and PUSH_ST are the stack cycles, and the pointer drops by one after each. VEC_LO reads the low vector byte and VEC_HI reads the high vector byte. The transitions are: IDLE to DUMMY on acceptance, otherwise IDLE stays in IDLE. DUMMY goes to PUSH_HI, PUSH_HI to PUSH_LO, PUSH_LO to PUSH_ST, PUSH_ST to VEC_LO, VEC_LO to VEC_HI, and VEC_HI back to IDLE with `done`. An active-low reset forces DUMMY from any state.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, `bus_we` is 0 and `done` is 0. After release the reset entry makes no write. It reads the vector at `$FFFC` (low) and `$FFFD` (high) and reports `new_pc` = that vector, `new_sp` = `$FC` and `new_status` = `$24`.
- R2: Vector addresses: the non-maskable request reads `$FFFA`/`$FFFB`, the maskable request and the break read `$FFFE`/`$FFFF`. The low byte is read first at the even address. `new_pc` = high byte × 256 + low byte.
- R3: The three stack cycles address `$0100 + sp`, starting from `sp_in` and decrementing by one after each cycle with wrap inside page 1. They carry the return address high byte, then its low byte, then the status byte. `new_sp` is `sp_in − 3` modulo 256. No write ever leaves page 1.
- R4: The pushed status byte equals `status_in` with bit 5 forced to 1. Bit 4 is 1 only when the entry is a break.
- R5: `new_status` equals `status_in` with bit 2 (interrupt disable) set, bit 4 cleared and bit 5 set. All other bits, including bit 3 (decimal), are unchanged.
- R6: A break pushes the break opcode address (`ret_pc`) + 2, modulo 65536. Hardware entries push `ret_pc` unchanged.
- R7: An accepted request gives six `busy` cycles, beginning at the cycle after acceptance. `done` is high for exactly the one cycle that follows them, so acceptance to the new fetch spans seven cycles.
- R8: The maskable request is taken only when `status_in` bit 2 is 0 at an instruction boundary. Otherwise it has no effect.
- R9: A 0-to-1 change of `nmi_req` is latched and causes exactly one entry at the next boundary, whatever bit 2 of `status_in` is. An edge that arrives while an entry runs is kept. A level that stays high does not cause a second entry.
- R10: Priority is reset, then non-maskable, then maskable, then break. A hardware request accepted together with `brk_hit` suppresses the break: its vector is used and bit 4 is pushed as 0, while the return address is still `ret_pc` + 2.
- R11: Asserting `rst_n` low during an entry aborts it. It clears any latched non-maskable edge and starts the reset entry again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the reset entry |
| nmi_req | input | 1 | Non-maskable request, edge-sensitive, active high |
| irq_req | input | 1 | Maskable request, level-sensitive, active high |
| at_boundary | input | 1 | Core is at an instruction boundary this cycle |
| brk_hit | input | 1 | Core fetched a break opcode this cycle |
| ret_pc | input | 16 | Return address, or break opcode address with `brk_hit` |
| status_in | input | 8 | Core status byte; bit 2 is interrupt disable |
| sp_in | input | 8 | Core stack pointer |
| bus_addr | output | 16 | Memory address while busy, 0 otherwise |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the same cycle as the address |
| bus_we | output | 1 | Write enable |
| busy | output | 1 | Sequencer owns the bus |
| done | output | 1 | One-cycle pulse: results valid |
| new_pc | output | 16 | Vector loaded into the program counter |
| new_sp | output | 8 | Stack pointer after the entry |
| new_status | output | 8 | Status byte after the entry |

## Verification
The bench builds the sequencer with its default parameters: a 16-bit address, an 8-bit data path, stack page 1 and the three vectors at the top of memory. With these values, a stack pointer of `$01` wraps to `$FF` in the middle of an entry, and a break at `$FFFF` wraps its return address to `$0001`. Both corners are driven. Simultaneous sources are applied in the same cycle so that every priority pair is observed at the bus. A reset is also asserted in the middle of an entry.

// File: rtl/entry_seq_pkg.sv
package entry_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DUMMY,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_VEC_LO,
        ST_VEC_HI
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_RESET,
        SRC_NMI,
        SRC_IRQ,
        SRC_BRK
    } entry_src_t;

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic clear,
    output logic pend
);
    logic prev_q;
    logic rise;

    assign rise = nmi_req & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= nmi_req;
            pend   <= (pend & ~clear) | rise;
        end
    end
endmodule

// File: rtl/entry_arbiter.sv
module entry_arbiter
    import entry_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int RET_SKIP = 2,
    parameter int I_BIT    = 2,
    parameter int B_BIT    = 4,
    parameter int U_BIT    = 5
) (
    input  logic              at_boundary,
    input  logic              brk_hit,
    input  logic              irq_req,
    input  logic              nmi_pend,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic [DATA_W-1:0] status_in,
    output logic              take,
    output entry_src_t        src,
    output logic [ADDR_W-1:0] push_pc,
    output logic [DATA_W-1:0] push_status,
    output logic [DATA_W-1:0] next_status
);
    logic at_slot;
    logic irq_ok;
    logic is_brk;

    assign at_slot = at_boundary | brk_hit;
    assign irq_ok  = irq_req & ~status_in[I_BIT];
    assign take    = (at_slot & (nmi_pend | irq_ok)) | brk_hit;

    always_comb begin
        if (at_slot && nmi_pend)    src = SRC_NMI;
        else if (at_slot && irq_ok) src = SRC_IRQ;
        else                        src = SRC_BRK;
    end

    assign is_brk  = (src == SRC_BRK);
    assign push_pc = brk_hit ? ret_pc + ADDR_W'(RET_SKIP) : ret_pc;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == B_BIT) begin : g_b
            assign push_status[i] = is_brk;
            assign next_status[i] = status_in[i] & 1'b0;
        end else if (i == U_BIT) begin : g_u
            assign push_status[i] = 1'b1;
            assign next_status[i] = status_in[i] | 1'b1;
        end else if (i == I_BIT) begin : g_i
            assign push_status[i] = status_in[i];
            assign next_status[i] = 1'b1;
        end else begin : g_pass
            assign push_status[i] = status_in[i];
            assign next_status[i] = status_in[i];
        end
    end
endmodule

// File: rtl/vector_select.sv
module vector_select
    import entry_seq_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] VEC_NMI   = 'hFFFA,
    parameter logic [ADDR_W-1:0] VEC_RESET = 'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_IRQ   = 'hFFFE
) (
    input  entry_src_t        src,
    output logic [ADDR_W-1:0] vec_base
);
    always_comb begin
        unique case (src)
            SRC_RESET: vec_base = VEC_RESET;
            SRC_NMI:   vec_base = VEC_NMI;
            default:   vec_base = VEC_IRQ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import entry_seq_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter int                DATA_W       = 8,
    parameter logic [DATA_W-1:0] STACK_PAGE   = 'h01,
    parameter logic [DATA_W-1:0] RESET_SP     = 'hFF,
    parameter logic [DATA_W-1:0] RESET_STATUS = 'h24,
    parameter logic [ADDR_W-1:0] VEC_NMI      = 'hFFFA,
    parameter logic [ADDR_W-1:0] VEC_RESET    = 'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_IRQ      = 'hFFFE,
    parameter int                RET_SKIP     = 2,
    parameter int                I_BIT        = 2,
    parameter int                B_BIT        = 4,
    parameter int                U_BIT        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic              at_boundary,
    input  logic              brk_hit,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] sp_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_we,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] new_pc,
    output logic [DATA_W-1:0] new_sp,
    output logic [DATA_W-1:0] new_status
);
    localparam int HI_LSB = ADDR_W - DATA_W;

    seq_state_t state, state_nx;

    logic              nmi_pend;
    logic              take;
    logic              accept;
    entry_src_t        arb_src;
    logic [ADDR_W-1:0] arb_pc;
    logic [DATA_W-1:0] arb_push_st;
    logic [DATA_W-1:0] arb_next_st;
    logic [ADDR_W-1:0] vec_base;

    entry_src_t        src_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] push_st_q;
    logic [DATA_W-1:0] next_st_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] vlo_q;

    nmi_edge_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .clear   (accept && (arb_src == SRC_NMI)),
        .pend    (nmi_pend)
    );

    entry_arbiter #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RET_SKIP (RET_SKIP),
        .I_BIT    (I_BIT),
        .B_BIT    (B_BIT),
        .U_BIT    (U_BIT)
    ) u_arb (
        .at_boundary (at_boundary),
        .brk_hit     (brk_hit),
        .irq_req     (irq_req),
        .nmi_pend    (nmi_pend),
        .ret_pc      (ret_pc),
        .status_in   (status_in),
        .take        (take),
        .src         (arb_src),
        .push_pc     (arb_pc),
        .push_status (arb_push_st),
        .next_status (arb_next_st)
    );

    vector_select #(
        .ADDR_W    (ADDR_W),
        .VEC_NMI   (VEC_NMI),
        .VEC_RESET (VEC_RESET),
        .VEC_IRQ   (VEC_IRQ)
    ) u_vec (
        .src      (src_q),
        .vec_base (vec_base)
    );

    assign accept = (state == ST_IDLE) && take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DUMMY;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE:    state_nx = accept ? ST_DUMMY : ST_IDLE;
            ST_DUMMY:   state_nx = ST_PUSH_HI;
            ST_PUSH_HI: state_nx = ST_PUSH_LO;
            ST_PUSH_LO: state_nx = ST_PUSH_ST;
            ST_PUSH_ST: state_nx = ST_VEC_LO;
            ST_VEC_LO:  state_nx = ST_VEC_HI;
            ST_VEC_HI:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // captured entry context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q      <= SRC_RESET;
            pc_q       <= '0;
            push_st_q  <= '0;
            next_st_q  <= RESET_STATUS;
            sp_q       <= RESET_SP;
            vlo_q      <= '0;
            done       <= 1'b0;
            new_pc     <= '0;
            new_sp     <= '0;
            new_status <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        src_q     <= arb_src;
                        pc_q      <= arb_pc;
                        push_st_q <= arb_push_st;
                        next_st_q <= arb_next_st;
                        sp_q      <= sp_in;
                    end
                end
                ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST: begin
                    sp_q <= sp_q - DATA_W'(1);
                end
                ST_VEC_LO: begin
                    vlo_q <= bus_rdata;
                end
                ST_VEC_HI: begin
                    new_pc     <= {bus_rdata, vlo_q};
                    new_sp     <= sp_q;
                    new_status <= next_st_q;
                    done       <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // bus outputs
    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_DUMMY: bus_addr = pc_q;
            ST_PUSH_HI: begin
                bus_addr  = {STACK_PAGE, sp_q};
                bus_wdata = pc_q[ADDR_W-1:HI_LSB];
                bus_we    = (src_q != SRC_RESET);
            end
            ST_PUSH_LO: begin
                bus_addr  = {STACK_PAGE, sp_q};
                bus_wdata = pc_q[DATA_W-1:0];
                bus_we    = (src_q != SRC_RESET);
            end
            ST_PUSH_ST: begin
                bus_addr  = {STACK_PAGE, sp_q};
                bus_wdata = push_st_q;
                bus_we    = (src_q != SRC_RESET);
            end
            ST_VEC_LO: bus_addr = vec_base;
            ST_VEC_HI: bus_addr = vec_base + ADDR_W'(1);
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/entry_seq_checker.sv
module entry_seq_checker #(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] STACK_PAGE = 'h01,
    parameter logic [ADDR_W-1:0] VEC_NMI    = 'hFFFA,
    parameter logic [ADDR_W-1:0] VEC_RESET  = 'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_IRQ    = 'hFFFE,
    parameter int                I_BIT      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] new_status,
    input logic              brk_hit,
    input logic [DATA_W-1:0] status_in,
    input logic              nmi_req,
    input logic              nmi_pend
);
    // R3
    stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_addr[ADDR_W-1:ADDR_W-DATA_W] == STACK_PAGE));

    // R2
    vector_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!$past(bus_we) &&
                  (($past(bus_addr) == VEC_NMI + ADDR_W'(1)) ||
                   ($past(bus_addr) == VEC_RESET + ADDR_W'(1)) ||
                   ($past(bus_addr) == VEC_IRQ + ADDR_W'(1)))));

    // R5
    disable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> new_status[I_BIT]);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R8
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk_hit && status_in[I_BIT] && !nmi_pend) |=> !busy);

    // R9
    nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |=> nmi_pend);
endmodule

bind irq_entry_seq entry_seq_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .VEC_NMI    (VEC_NMI),
    .VEC_RESET  (VEC_RESET),
    .VEC_IRQ    (VEC_IRQ),
    .I_BIT      (I_BIT)
) u_entry_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .new_status (new_status),
    .brk_hit    (brk_hit),
    .status_in  (status_in),
    .nmi_req    (nmi_req),
    .nmi_pend   (nmi_pend)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0, irq_req = 1'b0, at_boundary = 1'b0, brk_hit = 1'b0;
    logic [15:0] ret_pc = '0;
    logic [7:0]  status_in = '0, sp_in = '0;
    logic [15:0] bus_addr, new_pc;
    logic [7:0]  bus_wdata, bus_rdata, new_sp, new_status;
    logic        bus_we, busy, done;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        case (a)
            16'hFFFA: mem_byte = 8'h34;
            16'hFFFB: mem_byte = 8'h12;
            16'hFFFC: mem_byte = 8'h00;
            16'hFFFD: mem_byte = 8'hC0;
            16'hFFFE: mem_byte = 8'h78;
            16'hFFFF: mem_byte = 8'h56;
            default:  mem_byte = a[7:0] ^ 8'h5A;
        endcase
    endfunction

    assign bus_rdata = mem_byte(bus_addr);

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .at_boundary(at_boundary), .brk_hit(brk_hit), .ret_pc(ret_pc),
        .status_in(status_in), .sp_in(sp_in), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_we(bus_we),
        .busy(busy), .done(done), .new_pc(new_pc), .new_sp(new_sp),
        .new_status(new_status)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: kind 0 reset, 1 nmi, 2 irq, 3 break
    int          m_phase, m_kind;
    logic [15:0] m_pc, m_npc;
    logic [7:0]  m_sp, m_pp, m_ns, m_nsp, m_nst;
    bit          m_pend, m_prev, m_done;

    function automatic logic [15:0] vbase(input int k);
        vbase = (k == 0) ? 16'hFFFC : (k == 1) ? 16'hFFFA : 16'hFFFE;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 1; m_kind = 0; m_pc = 16'h0; m_sp = 8'hFF;
            m_pp = 8'h00; m_ns = 8'h24; m_pend = 0; m_prev = 0; m_done = 0;
        end else begin
            bit rise, slot, irqok, tk;
            rise = nmi_req && !m_prev;
            m_prev = nmi_req;
            m_done = 0;
            if (m_phase == 0) begin
                slot = at_boundary || brk_hit;
                irqok = irq_req && !status_in[2];
                tk = 1;
                if (slot && m_pend) begin m_kind = 1; m_pend = 0; end
                else if (slot && irqok) m_kind = 2;
                else if (brk_hit) m_kind = 3;
                else tk = 0;
                if (tk) begin
                    m_pc = brk_hit ? ret_pc + 16'd2 : ret_pc;
                    m_pp = (status_in | 8'h20) & 8'hEF;
                    if (m_kind == 3) m_pp = m_pp | 8'h10;
                    m_ns = ((status_in | 8'h24) & 8'hEF);
                    m_sp = sp_in;
                    m_phase = 1;
                end
            end else if (m_phase >= 2 && m_phase <= 4) begin
                m_sp = m_sp - 8'd1;
                m_phase++;
            end else if (m_phase == 6) begin
                m_phase = 0; m_done = 1;
                m_npc = {mem_byte(vbase(m_kind) + 16'd1), mem_byte(vbase(m_kind))};
                m_nsp = m_sp; m_nst = m_ns;
            end else begin
                m_phase++;
            end
            if (rise) m_pend = 1;
        end
    end

    int          done_cnt = 0, busy_cnt = 0;
    logic [15:0] last_pc;
    logic [7:0]  last_sp, last_st;
    logic [7:0]  wr_q[$];

    // per-clock comparison against the reference
    always @(negedge clk) begin
        logic [15:0] ea;
        logic        ewe;
        logic [7:0]  ewd;
        ea = 16'h0; ewe = 0; ewd = 8'h0;
        case (m_phase)
            1: ea = m_pc;
            2: begin ea = {8'h01, m_sp}; ewe = (m_kind != 0); ewd = m_pc[15:8]; end
            3: begin ea = {8'h01, m_sp}; ewe = (m_kind != 0); ewd = m_pc[7:0]; end
            4: begin ea = {8'h01, m_sp}; ewe = (m_kind != 0); ewd = m_pp; end
            5: ea = vbase(m_kind);
            6: ea = vbase(m_kind) + 16'd1;
            default: ;
        endcase
        chk(busy == (m_phase != 0), rst_n ? "R7 busy" : "R1 busy in reset", busy, m_phase != 0);
        chk(bus_we == ewe, (m_kind == 0) ? "R1 no write" : "R3 write enable", bus_we, ewe);
        chk(bus_addr == ea, (m_phase >= 5) ? "R2 vector address" : "R3 stack address", bus_addr, ea);
        if (ewe) chk(bus_wdata == ewd, (m_phase == 4) ? "R4 pushed status" : "R6 pushed return address", bus_wdata, ewd);
        chk(done == m_done, "R7 done pulse", done, m_done);
        if (m_done && done) begin
            chk(new_pc == m_npc, "R2 new_pc", new_pc, m_npc);
            chk(new_sp == m_nsp, "R3 new_sp", new_sp, m_nsp);
            chk(new_status == m_nst, "R5 new_status", new_status, m_nst);
        end
        if (done) begin done_cnt++; last_pc = new_pc; last_sp = new_sp; last_st = new_status; end
        if (busy) busy_cnt++;
        if (bus_we) wr_q.push_back(bus_wdata);
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clear_obs();
        wr_q.delete();
        busy_cnt = 0;
    endtask

    task automatic chk_writes(input string tag, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        chk(wr_q.size() == 3, tag, wr_q.size(), 3);
        if (wr_q.size() == 3) begin
            chk(wr_q[0] == a, tag, wr_q[0], a);
            chk(wr_q[1] == b, tag, wr_q[1], b);
            chk(wr_q[2] == c, tag, wr_q[2], c);
        end
    endtask

    // one-cycle request at a boundary
    task automatic enter(input bit brk, input bit irq, input logic [15:0] pc,
                         input logic [7:0] st, input logic [7:0] sp);
        ret_pc = pc; status_in = st; sp_in = sp; irq_req = irq;
        brk_hit = brk; at_boundary = !brk;
        tick(1);
        brk_hit = 0; at_boundary = 0; irq_req = 0;
    endtask

    int base;

    initial begin
        // R1: reset state and reset entry
        tick(3);
        rst_n = 1'b1;
        clear_obs();
        tick(10);
        chk(last_pc == 16'hC000, "R1 reset vector", last_pc, 16'hC000);
        chk(last_sp == 8'hFC, "R1 reset sp", last_sp, 8'hFC);
        chk(last_st == 8'h24, "R1 reset status", last_st, 8'h24);
        chk(wr_q.size() == 0, "R1 no stack writes", wr_q.size(), 0);

        // R3/R7: maskable entry
        clear_obs();
        enter(0, 1, 16'h2000, 8'h81, 8'hF0);
        tick(10);
        chk_writes("R3 push order", 8'h20, 8'h00, 8'hA1);
        chk(busy_cnt == 6, "R7 busy length", busy_cnt, 6);
        chk(last_sp == 8'hED, "R3 sp after", last_sp, 8'hED);
        chk(last_st == 8'hA5, "R5 status after", last_st, 8'hA5);
        chk(last_pc == 16'h5678, "R2 maskable vector", last_pc, 16'h5678);

        // R8: masked request held at boundaries
        clear_obs();
        base = done_cnt;
        status_in = 8'h0C; irq_req = 1; at_boundary = 1;
        tick(8);
        irq_req = 0; at_boundary = 0;
        tick(2);
        chk(busy_cnt == 0, "R8 masked irq", busy_cnt, 0);
        chk(done_cnt == base, "R8 no entry", done_cnt, base);

        // R9: edge latched off-boundary, taken despite mask
        clear_obs();
        base = done_cnt;
        nmi_req = 1; tick(1); nmi_req = 0; tick(3);
        enter(0, 0, 16'h4000, 8'h0C, 8'hE0);
        tick(10);
        chk(done_cnt == base + 1, "R9 one nmi entry", done_cnt, base + 1);
        chk(last_pc == 16'h1234, "R9 nmi vector", last_pc, 16'h1234);
        chk(last_st == 8'h2C, "R5 decimal kept", last_st, 8'h2C);

        // R9: held level gives one entry only
        base = done_cnt;
        nmi_req = 1; tick(2);
        enter(0, 0, 16'h4100, 8'h04, 8'hE0);
        tick(10);
        clear_obs();
        enter(0, 0, 16'h4200, 8'h04, 8'hE0);
        tick(10);
        nmi_req = 0;
        chk(done_cnt == base + 1, "R9 held level", done_cnt, base + 1);
        chk(busy_cnt == 0, "R9 no second entry", busy_cnt, 0);

        // R6/R4: break
        clear_obs();
        enter(1, 0, 16'h3000, 8'h00, 8'h80);
        tick(10);
        chk_writes("R6 break push", 8'h30, 8'h02, 8'h30);
        chk(last_pc == 16'h5678, "R2 break vector", last_pc, 16'h5678);
        chk(last_st == 8'h24, "R5 break status", last_st, 8'h24);

        // R10: break with maskable request
        clear_obs();
        enter(1, 1, 16'h3100, 8'h00, 8'h80);
        tick(10);
        chk_writes("R10 irq over break", 8'h31, 8'h02, 8'h20);

        // R10: break with pending non-maskable edge
        clear_obs();
        nmi_req = 1; tick(1); nmi_req = 0; tick(1);
        enter(1, 0, 16'h3200, 8'h00, 8'h80);
        tick(10);
        chk_writes("R10 nmi over break", 8'h32, 8'h02, 8'h20);
        chk(last_pc == 16'h1234, "R10 nmi vector", last_pc, 16'h1234);

        // R10: nmi before irq, then irq
        clear_obs();
        nmi_req = 1; tick(1); nmi_req = 0; tick(1);
        enter(0, 1, 16'h5000, 8'h00, 8'hC0);
        tick(10);
        chk(last_pc == 16'h1234, "R10 nmi first", last_pc, 16'h1234);
        enter(0, 1, 16'h1234, 8'h00, 8'hBD);
        tick(10);
        chk(last_pc == 16'h5678, "R10 irq second", last_pc, 16'h5678);

        // R9: edge during a running entry is kept
        base = done_cnt;
        enter(0, 1, 16'h6000, 8'h00, 8'hA0);
        tick(2);
        nmi_req = 1; tick(1); nmi_req = 0;
        tick(8);
        enter(0, 0, 16'h5678, 8'h04, 8'h9D);
        tick(10);
        chk(done_cnt == base + 2, "R9 kept edge", done_cnt, base + 2);
        chk(last_pc == 16'h1234, "R9 kept edge vector", last_pc, 16'h1234);

        // R3/R6: stack and address wrap
        clear_obs();
        enter(1, 0, 16'hFFFF, 8'h00, 8'h01);
        tick(10);
        chk_writes("R6 pc wrap", 8'h00, 8'h01, 8'h30);
        chk(last_sp == 8'hFE, "R3 sp wrap", last_sp, 8'hFE);

        // R11: reset during an entry
        enter(0, 1, 16'h7000, 8'h00, 8'h90);
        tick(1);
        nmi_req = 1; tick(1); nmi_req = 0;
        rst_n = 0; tick(2); rst_n = 1;
        clear_obs();
        tick(10);
        chk(last_pc == 16'hC000, "R11 restart reset", last_pc, 16'hC000);
        chk(wr_q.size() == 0, "R11 no writes", wr_q.size(), 0);
        clear_obs();
        enter(0, 0, 16'h8000, 8'h04, 8'hFC);
        tick(8);
        chk(busy_cnt == 0, "R11 nmi latch cleared", busy_cnt, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule